// File: doc/BRIEF.md
# Adaptive Cluster Fold Router

This block sits between four memory banks and four identical compute clusters. Each bank has one data stream. The block sends those streams to the clusters in one of four arrangements, and it picks the arrangement from a count of the data parallelism that is available. With plenty of parallelism each cluster takes its own bank. With less parallelism the four streams are time-shared onto two clusters or onto one cluster. With none, every cluster is shut down.

Any cluster that the current arrangement does not use gets a sleep (power-gate) signal. Its data output is held at zero and its valid flag is held low. The arrangement changes only at a stream boundary, which is a clock edge at which no bank presents valid data. A stream that is already in flight therefore never sees its routing change halfway through.

Routing goes through one register stage. A bank word sampled at one clock edge appears on the cluster outputs right after that edge.

Top module: `cluster_fold_router`

## Requirements
- R1: In full mode, cluster i outputs bank i's data and valid, with one register of latency. Bank i is bits [16*i +: 16] of the bank bus, and the same bit positions hold cluster i on the cluster bus.
- R2: The mode is decoded from the parallelism count as follows:
  - a count of 4 or more selects full mode (4 active clusters);
  - a count of 2 or 3 selects half mode (2 active);
  - a count of 1 selects single mode (1 active);
  - a count of 0 selects off mode (0 active).
- R3: Half mode depends on the phase p:
  - cluster 0 outputs bank 0 when p is even and bank 2 when p is odd;
  - cluster 1 outputs bank 1 when p is even and bank 3 when p is odd;
  - the valid output follows the valid flag of the bank selected that cycle.
- R4: In single mode, cluster 0 outputs bank p, where p is the phase (0 to 3), with that bank's valid flag. Clusters 1 to 3 stay idle.
- R5: A cluster whose index is not below the active count has zero data, low valid, and its sleep bit set to 1. Active clusters have their sleep bit at 0.
- R6: The mode register loads the decoded count only at an edge where all four bank valid flags are low. While any flag is high, the mode and the sleep outputs hold their values, whatever the count does.
- R7: The phase is a 2-bit counter. It returns to 0 at every edge where all bank valid flags are low, and at every other edge it adds 1, wrapping from 3 to 0.
- R8: A synchronous active-high reset selects off mode, clears phase and outputs, and sets all four sleep bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| par_count | input | CNT_W (8) | Data-parallelism count |
| bank_data | input | 4*DATA_W (64) | Bank streams, bank i at [DATA_W*i +: DATA_W] |
| bank_valid | input | 4 | Per-bank valid flags |
| cl_data | output | 4*DATA_W (64) | Cluster streams, cluster i at [DATA_W*i +: DATA_W] |
| cl_valid | output | 4 | Per-cluster valid flags |
| cl_sleep | output | 4 | Per-cluster power-gate request, 1 = gated |

## Verification
Two things can happen on the same edge: a stream boundary, where the mode is reloaded and the phase returns to 0, and the routing of words under the old mode. The bench produces this on purpose. It holds a new parallelism count steady while streams are still running, and then it follows a single idle cycle straight away with fresh valid data. A reference model loads the mode only on idle edges and routes each sampled word with the mode and phase that were in force before that edge. The bench then checks both the routed outputs and the sleep bits against this model, under directed sequences and under seeded random traffic with frequent idle gaps.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
    localparam int NUM_CL = 4;
    localparam int PH_W   = 2;

    typedef enum logic [1:0] {
        M_OFF  = 2'd0,
        M_ONE  = 2'd1,
        M_HALF = 2'd2,
        M_ALL  = 2'd3
    } fold_mode_e;

    typedef struct packed {
        fold_mode_e        mode;
        logic [PH_W-1:0]   phase;
    } sched_t;

    function automatic fold_mode_e pick_mode(input int unsigned cnt);
        if (cnt >= 4)      return M_ALL;
        else if (cnt >= 2) return M_HALF;
        else if (cnt == 1) return M_ONE;
        else               return M_OFF;
    endfunction

    function automatic int active_of(input fold_mode_e m);
        case (m)
            M_ALL:   return 4;
            M_HALF:  return 2;
            M_ONE:   return 1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [NUM_CL-1:0] sleep_mask(input fold_mode_e m);
        logic [NUM_CL-1:0] mk;
        for (int i = 0; i < NUM_CL; i++) mk[i] = (i >= active_of(m));
        return mk;
    endfunction
endpackage

// File: rtl/cfr_sched.sv
module cfr_sched
    import cfr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  par_count,
    input  logic [NUM_CL-1:0] bank_valid,
    output sched_t            sched
);
    sched_t q;
    logic   idle;

    assign idle  = ~|bank_valid;
    assign sched = q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q.mode  <= M_OFF;
            q.phase <= '0;
        end else if (idle) begin
            q.mode  <= pick_mode(32'(par_count));
            q.phase <= '0;
        end else begin
            q.phase <= q.phase + 1'b1;
        end
    end

    // R6: mode frozen while any stream is live
    assert_mode_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!idle) |=> $stable(q.mode));

    // R7: phase restarts after a boundary
    assert_phase_restart_R7: assert property (@(posedge clk) disable iff (rst)
        idle |=> (q.phase == '0));

    // R8: reset lands in off mode
    assert_reset_off_R8: assert property (@(posedge clk)
        rst |=> (q.mode == M_OFF && q.phase == '0));
endmodule

// File: rtl/cfr_lane.sv
module cfr_lane
    import cfr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX    = 0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  sched_t                   sched,
    input  logic [NUM_CL*DATA_W-1:0] bank_data,
    input  logic [NUM_CL-1:0]        bank_valid,
    output logic [DATA_W-1:0]        out_data,
    output logic                     out_valid
);
    localparam logic [PH_W-1:0] IDX_B = PH_W'(IDX);

    logic [PH_W-1:0] src;
    logic            en;

    always_comb begin
        en = (IDX < active_of(sched.mode));
        case (sched.mode)
            M_HALF:  src = {sched.phase[0], IDX_B[0]};
            M_ONE:   src = sched.phase;
            default: src = IDX_B;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= en & bank_valid[src];
            out_data  <= en ? bank_data[int'(src)*DATA_W +: DATA_W] : '0;
        end
    end

    // R5: an unused lane emits nothing on the following cycle
    assert_idle_lane_R5: assert property (@(posedge clk) disable iff (rst)
        (IDX >= active_of(sched.mode)) |=> (!out_valid && out_data == '0));
endmodule

// File: rtl/cluster_fold_router.sv
module cluster_fold_router
    import cfr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [CNT_W-1:0]         par_count,
    input  logic [NUM_CL*DATA_W-1:0] bank_data,
    input  logic [NUM_CL-1:0]        bank_valid,
    output logic [NUM_CL*DATA_W-1:0] cl_data,
    output logic [NUM_CL-1:0]        cl_valid,
    output logic [NUM_CL-1:0]        cl_sleep
);
    sched_t sched;

    cfr_sched #(.CNT_W(CNT_W)) u_sched (
        .clk        (clk),
        .rst        (rst),
        .par_count  (par_count),
        .bank_valid (bank_valid),
        .sched      (sched)
    );

    for (genvar g = 0; g < NUM_CL; g++) begin : g_lane
        cfr_lane #(.DATA_W(DATA_W), .IDX(g)) u_lane (
            .clk        (clk),
            .rst        (rst),
            .sched      (sched),
            .bank_data  (bank_data),
            .bank_valid (bank_valid),
            .out_data   (cl_data[g*DATA_W +: DATA_W]),
            .out_valid  (cl_valid[g])
        );
    end

    assign cl_sleep = sleep_mask(sched.mode);

    // R5: a gated cluster never shows valid data
    assert_gated_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (cl_sleep & cl_valid) == '0);

    // R4: single mode drives cluster 0 only
    assert_single_lane_R4: assert property (@(posedge clk) disable iff (rst)
        (sched.mode == M_ONE) |=> (cl_valid[NUM_CL-1:1] == '0));
endmodule

// File: tb/cluster_fold_router_test.sv
`timescale 1ns/1ps
module cluster_fold_router_test;
    localparam int DW = 16;
    localparam int NC = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [7:0]        par_count = '0;
    logic [NC*DW-1:0]  bank_data = '0;
    logic [NC-1:0]     bank_valid = '0;
    logic [NC*DW-1:0]  cl_data;
    logic [NC-1:0]     cl_valid;
    logic [NC-1:0]     cl_sleep;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int m_act  = 0;
    int m_ph   = 0;

    always #4 clk = ~clk;

    cluster_fold_router uut (
        .clk(clk), .rst(rst), .par_count(par_count),
        .bank_data(bank_data), .bank_valid(bank_valid),
        .cl_data(cl_data), .cl_valid(cl_valid), .cl_sleep(cl_sleep)
    );

    function automatic int dec_act(input int c);
        if (c >= 4) return 4;
        if (c >= 2) return 2;
        if (c == 1) return 1;
        return 0;
    endfunction

    function automatic logic [NC-1:0] exp_sleep(input int act);
        logic [NC-1:0] s;
        for (int i = 0; i < NC; i++) s[i] = (i >= act);
        return s;
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, model the edge, compare at next negedge
    task automatic step(input string tag, input int pc, input logic [NC-1:0] bv,
                        input logic [NC*DW-1:0] bd);
        logic [NC*DW-1:0] ed;
        logic [NC-1:0]    ev;
        string t;
        par_count  = 8'(pc);
        bank_valid = bv;
        bank_data  = bd;
        ed = '0;
        ev = '0;
        for (int i = 0; i < NC; i++) begin
            int src;
            if (i < m_act) begin
                if (m_act == 4)      src = i;
                else if (m_act == 2) src = i + 2 * (m_ph % 2);
                else                 src = m_ph;
                ev[i] = bv[src];
                ed[i*DW +: DW] = bd[src*DW +: DW];
            end
        end
        if (tag != "")       t = tag;
        else if (m_act == 4) t = "R1";
        else if (m_act == 2) t = "R3";
        else if (m_act == 1) t = "R4";
        else                 t = "R5";
        if (bv == '0) begin
            m_act = dec_act(pc);
            m_ph  = 0;
        end else begin
            m_ph = (m_ph + 1) % 4;
        end
        @(posedge clk);
        @(negedge clk);
        check({t, " data/valid"}, {60'd0, ev, cl_data}, {60'd0, ev, ed});
        check({t, " valid"}, 128'(cl_valid), 128'(ev));
        check("R6 sleep", 128'(cl_sleep), 128'(exp_sleep(m_act)));
    endtask

    function automatic logic [NC*DW-1:0] rnd_data();
        return {$urandom, $urandom};
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 data", 128'(cl_data), 128'd0);
        check("R8 valid", 128'(cl_valid), 128'd0);
        check("R8 sleep", 128'(cl_sleep), 128'hF);
        rst = 1'b0;
        m_act = 0;
        m_ph  = 0;

        // R2: count 7 selects full mode at an idle edge
        step("R2", 7, 4'h0, rnd_data());
        for (int k = 0; k < 4; k++) step("", 7, 4'($urandom), rnd_data());
        // R6: count changes while streams are live, mode must hold
        for (int k = 0; k < 3; k++) step("R6", 1, 4'hF, rnd_data());
        // R2: count 3 selects half mode; R7 phase walk
        step("R2", 3, 4'h0, rnd_data());
        for (int k = 0; k < 6; k++) step("R7", 3, 4'hF, rnd_data());
        // single idle cycle then fresh data: boundary and routing on adjacent edges
        step("R7", 1, 4'h0, rnd_data());
        for (int k = 0; k < 8; k++) step("R4", 1, 4'($urandom | 1), rnd_data());
        // off mode
        step("R2", 0, 4'h0, rnd_data());
        for (int k = 0; k < 4; k++) step("R5", 0, 4'hF, rnd_data());
        // large count selects full mode
        step("R2", 200, 4'h0, rnd_data());
        for (int k = 0; k < 3; k++) step("R1", 200, 4'hF, rnd_data());

        // seeded random traffic
        for (int k = 0; k < 3000; k++) begin
            int pc = int'($urandom % 8);
            logic [NC-1:0] bv = (($urandom % 4) == 0) ? 4'h0 : 4'($urandom);
            step("", pc, bv, rnd_data());
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule